// File: doc/BRIEF.md
# Jittered-Period PWM Carrier

This block drives a single PWM output whose carrier period changes slightly from one cycle to the next. A fixed carrier puts all of its switching energy into one narrow spectral line and its harmonics. Moving the period by a few ticks on every cycle spreads that energy over a band around the nominal frequency. The duty ratio is kept at the configured value by rescaling the compare threshold to fit each period.

The period length and the compare threshold are supplied as plain input words. An internal 16-bit linear-feedback shift register chooses a signed offset at every period boundary. At that same boundary the block latches a new length and threshold. A strobe marks the first tick of each period. When dithering is switched off, the block behaves as a plain fixed-period PWM.

Top module: `dpwm_carrier`

## Requirements
- R1: While reset is held (rst_n low, asynchronous), `pwm_o` and `period_start_o` are 0 and the random register is loaded with the non-zero seed 0xACE1.
- R2: With `dith_en` high, each period lasts `base_period + off` ticks. `off` is the low 3 bits of the random register value held before the boundary, read as 0..7, minus 3, which gives an offset from -3 to +4.
- R3: The random register shifts left by one bit at every period boundary and at no other time. The new bit 0 is bit15 XOR bit13 XOR bit12 XOR bit10. The register never holds zero.
- R4: With `dith_en` high, the period's compare threshold is floor(`base_cmp` × period / `base_period`). The product is formed at twice the word width, and the result saturates at 2^W−1.
- R5: With `dith_en` low, every period lasts exactly `base_period` ticks and the threshold equals `base_cmp` exactly.
- R6: `pwm_o` is high on a tick whose position in the period (counted from 0) is below the threshold. A threshold of 0 keeps the output low for the whole period. A threshold at or above the period length keeps it high for the whole period.
- R7: `period_start_o` is high for exactly the first tick of each period. Period length and threshold change only at a boundary, together.
- R8: `base_period`, `base_cmp` and `dith_en` are sampled only on the boundary edge. A change made in the middle of a period first affects the following period.
- R9: The first boundary happens on the first clock edge where `run_en` is high while the block is idle. A clock edge with `run_en` low returns the block to idle, and both outputs are 0 from then until the next boundary. The supported range of `base_period` is 8 to 2^W−5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run the carrier |
| dith_en | input | 1 | Enable period jitter |
| base_period | input | W (16) | Nominal period in ticks |
| base_cmp | input | W (16) | Nominal compare threshold |
| pwm_o | output | 1 | PWM output |
| period_start_o | output | 1 | First-tick-of-period strobe |

## Verification
Two events can fall on the same clock edge: the period boundary, which latches a new length and threshold, and a change to the base inputs. The stimulus table applies each new configuration at a fixed cycle count, with no regard to where the running period stands. Some of these changes therefore land on the last tick of a period and some land in its middle. The bench predicts every period from the input values present on the boundary edge itself, and compares both the measured period length and the count of high ticks against that prediction.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // Fibonacci step, taps 16,14,13,11 (maximal length)
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] q);
    return {q[LFSR_W-2:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
  endfunction

  // low three random bits mapped to -3..+4
  function automatic logic signed [3:0] dither_offset(input logic [2:0] r);
    return $signed({1'b0, r}) - 4'sd3;
  endfunction
endpackage

// File: rtl/dpwm_lfsr.sv
module dpwm_lfsr
  import dpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [LFSR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= LFSR_SEED;
    else if (adv) q <= lfsr_step(q);
  end
endmodule

// File: rtl/dpwm_scaler.sv
module dpwm_scaler
  import dpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] base_period,
  input  logic [W-1:0] base_cmp,
  input  logic         dith_en,
  input  logic [2:0]   rnd,
  output logic [W-1:0] nxt_period,
  output logic [W-1:0] nxt_cmp
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0] ALL1 = '1;

  // proportional threshold at double width, saturating
  function automatic logic [W-1:0] scale_cmp(input logic [W-1:0] bc,
                                             input logic [W-1:0] per,
                                             input logic [W-1:0] bp);
    logic [PW-1:0] prod;
    logic [PW-1:0] quo;
    prod = {{W{1'b0}}, bc} * {{W{1'b0}}, per};
    if (bp == '0) return bc;
    quo = prod / {{W{1'b0}}, bp};
    if (|quo[PW-1:W]) return ALL1;
    return quo[W-1:0];
  endfunction

  logic signed [3:0] off;
  logic [W:0]        sum;

  always_comb begin
    off = dith_en ? dither_offset(rnd) : 4'sd0;
    sum = {1'b0, base_period} + {{(W-3){off[3]}}, off};
    nxt_period = sum[W] ? ALL1 : sum[W-1:0];
    nxt_cmp    = dith_en ? scale_cmp(base_cmp, nxt_period, base_period) : base_cmp;
  end
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic [W-1:0] nxt_period,
  input  logic [W-1:0] nxt_cmp,
  output logic         bnd,
  output logic         active,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cur_period,
  output logic [W-1:0] cur_cmp,
  output logic         pwm_o,
  output logic         period_start_o
);
  localparam logic [W-1:0] ONE = 1;

  assign bnd = run_en && (!active || cnt == cur_period - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      cur_period <= '0;
      cur_cmp    <= '0;
    end else if (!run_en) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (bnd) begin
      active     <= 1'b1;
      cnt        <= '0;
      cur_period <= nxt_period;
      cur_cmp    <= nxt_cmp;
    end else begin
      cnt <= cnt + ONE;
    end
  end

  assign pwm_o          = active && (cnt < cur_cmp);
  assign period_start_o = active && (cnt == '0);
endmodule

// File: rtl/dpwm_carrier.sv
module dpwm_carrier
  import dpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         dith_en,
  input  logic [W-1:0] base_period,
  input  logic [W-1:0] base_cmp,
  output logic         pwm_o,
  output logic         period_start_o
);
  logic              bnd;
  logic              active;
  logic [W-1:0]      cnt;
  logic [W-1:0]      cur_period;
  logic [W-1:0]      cur_cmp;
  logic [W-1:0]      nxt_period;
  logic [W-1:0]      nxt_cmp;
  logic [LFSR_W-1:0] lfsr_q;

  dpwm_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(bnd), .q(lfsr_q)
  );

  dpwm_scaler #(.W(W)) u_scale (
    .base_period(base_period), .base_cmp(base_cmp), .dith_en(dith_en),
    .rnd(lfsr_q[2:0]), .nxt_period(nxt_period), .nxt_cmp(nxt_cmp)
  );

  dpwm_timebase #(.W(W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .nxt_period(nxt_period), .nxt_cmp(nxt_cmp),
    .bnd(bnd), .active(active), .cnt(cnt),
    .cur_period(cur_period), .cur_cmp(cur_cmp),
    .pwm_o(pwm_o), .period_start_o(period_start_o)
  );
endmodule

// File: rtl/dpwm_carrier_chk.sv
module dpwm_carrier_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic         pwm_o,
  input logic         period_start_o,
  input logic         bnd,
  input logic         active,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cur_period,
  input logic [W-1:0] cur_cmp,
  input logic [15:0]  lfsr_q
);
  a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0);
  a_r3_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(lfsr_q));
  a_r3_lfsr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> lfsr_q != $past(lfsr_q));
  a_r7_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(cur_period) && $stable(cur_cmp));
  a_r7_strobe_after_bnd: assert property (@(posedge clk) disable iff (!rst_n)
    period_start_o |-> $past(bnd));
  a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt < cur_period);
  a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    cur_cmp == '0 |-> !pwm_o);
  a_r6_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    active && cur_cmp >= cur_period |-> pwm_o);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !pwm_o && !period_start_o);
endmodule

bind dpwm_carrier dpwm_carrier_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwm_o(pwm_o),
  .period_start_o(period_start_o), .bnd(bnd), .active(active), .cnt(cnt),
  .cur_period(cur_period), .cur_cmp(cur_cmp), .lfsr_q(lfsr_q)
);

// File: tb/dpwm_carrier_tb.sv
module dpwm_carrier_tb;
  localparam int W = 16;
  // {base_period, base_cmp, dith_en, cycles}
  localparam int NV = 9;
  localparam logic [48:0] VEC [NV] = '{
    {16'd10,    16'd5,     1'b1, 16'd400},
    {16'd64,    16'd16,    1'b1, 16'd800},
    {16'd64,    16'd16,    1'b0, 16'd400},
    {16'd100,   16'd65535, 1'b1, 16'd600},
    {16'd20,    16'd0,     1'b1, 16'd200},
    {16'd20,    16'd20,    1'b1, 16'd200},
    {16'd8,     16'd7,     1'b1, 16'd300},
    {16'd37,    16'd11,    1'b0, 16'd301},
    {16'd200,   16'd50,    1'b1, 16'd1500}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic dith_en = 1'b0;
  logic [W-1:0] base_period = 16'd10;
  logic [W-1:0] base_cmp = 16'd5;
  logic pwm_o, period_start_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dpwm_carrier #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .dith_en(dith_en),
    .base_period(base_period), .base_cmp(base_cmp),
    .pwm_o(pwm_o), .period_start_o(period_start_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_next(input logic [15:0] s);
    return {s[14:0], ^(s & 16'hB400)};
  endfunction

  // inputs as seen on each rising edge
  logic          s_run, s_dith;
  logic [W-1:0]  s_bp, s_bc;
  always @(posedge clk) begin
    s_run  <= run_en;
    s_dith <= dith_en;
    s_bp   <= base_period;
    s_bc   <= base_cmp;
  end

  logic [15:0] m_lfsr = 16'hACE1;
  bit     in_per = 1'b0;
  bit     per_dith = 1'b0;
  longint len, hi, exp_len, exp_hi;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!s_run) begin
        in_per = 1'b0;
        check("R9 idle pwm", pwm_o, 0);
        check("R9 idle strobe", period_start_o, 0);
      end else if (period_start_o) begin
        longint per, cmp;
        int off;
        if (in_per) begin
          check(per_dith ? "R2 R3 R7 R8 length" : "R5 R7 R8 length", len, exp_len);
          check("R4 R6 high ticks", hi, exp_hi);
        end
        off = s_dith ? int'(m_lfsr[2:0]) - 3 : 0;
        per = longint'(s_bp) + off;
        if (s_dith) begin
          cmp = (longint'(s_bc) * per) / longint'(s_bp);
          if (cmp > 65535) cmp = 65535;
        end else cmp = s_bc;
        exp_len = per;
        exp_hi  = (cmp < per) ? cmp : per;
        per_dith = s_dith;
        m_lfsr = model_next(m_lfsr);
        in_per = 1'b1;
        len = 1;
        hi  = pwm_o;
      end else if (in_per) begin
        len++;
        hi += pwm_o;
      end
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pwm", pwm_o, 0);
    check("R1 reset strobe", period_start_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 R9 post-reset pwm", pwm_o, 0);
    check("R1 R9 post-reset strobe", period_start_o, 0);

    // table walk; configuration changes land at arbitrary period phases
    run_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      base_period = VEC[i][48:33];
      base_cmp    = VEC[i][32:17];
      dith_en     = VEC[i][16];
      repeat (int'(VEC[i][15:0])) @(negedge clk);
    end

    // R9: drop run_en mid-period, then restart
    run_en = 1'b0;
    @(negedge clk);
    check("R9 stop pwm", pwm_o, 0);
    check("R9 stop strobe", period_start_o, 0);
    repeat (5) @(negedge clk);
    base_period = 16'd12; base_cmp = 16'd12; dith_en = 1'b0;
    run_en = 1'b1;
    @(negedge clk);
    check("R9 restart strobe", period_start_o, 1);
    check("R6 full pwm", pwm_o, 1);
    repeat (60) @(negedge clk);

    // R8: mid-period change must not disturb the running period
    base_cmp = 16'd3;
    repeat (80) @(negedge clk);
    run_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule